// File: doc/BRIEF.md
# Saturating Two-Digit Up/Down Display Counter

This block keeps a decimal value between 00 and 99. Two active-low push buttons move the value: one steps it up and one steps it down. The value stops at either end and does not roll over. Only a fresh press changes the value. A button held down, or a button let go, does nothing. The buttons pass through a two-flop synchroniser. They are then sampled once per display slot, at the slot boundary.

The value goes out on two multiplexed seven-segment digits that share one set of segment lines. A prescaler divides the system clock into display slots. Each slot lights one digit, so the tens and ones digits take turns. Each slot boundary runs the same sequence:
1. The segment lines go blank.
2. On the next cycle the one-hot digit enables swap.
3. One cycle later the new digit's pattern appears.

This sequence stops the old pattern from showing on the new digit. The binary value is split into tens and ones by a fixed chain of four restoring trial subtractions.

Top module: `updown_display_counter`

## Requirements
- R1: During reset and after it the value is 00, the digit enables read 2'b01 (ones digit, bit 0), and the segment lines are all zero until the first slot boundary. Both buttons start out as released.
- R2: A slot boundary comes every SLOT_CYCLES clock cycles. The digit enables are always one-hot and swap exactly once per slot, so each digit is lit in every other slot.
- R3: Whenever the digit enables change, the segment lines are zero in that cycle. They go blank one cycle before the swap and carry the new pattern one cycle after it.
- R4: A button change from released (high) to pressed (low), seen at a slot boundary, adds one to the value on the Up button. A held button or a release leaves the value unchanged.
- R5: A fresh press of the Down button subtracts one from the value.
- R6: When fresh presses of both buttons are seen at the same boundary, only the Down step happens.
- R7: Stepping up from 99 leaves the value at 99. The value never goes above 99.
- R8: Stepping down from 00 leaves the value at 00.
- R9: The segment bus is active high: bit 0 drives segment A and bit 6 drives segment G. The digit patterns are 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F.
- R10: With enable 2'b01 the segments show the ones digit of the current value. With 2'b10 they show the tens digit. The tens digit comes from trial subtractions of 80, 40, 20 and 10, in that order.
- R11: Button levels are sampled only at slot boundaries, through a two-flop synchroniser. A press that is low for only a few cycles in the middle of a slot, and high again well before the next boundary, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_up_n | input | 1 | Up push button, active low, asynchronous |
| btn_dn_n | input | 1 | Down push button, active low, asynchronous |
| seg_o | output | 7 | Segment lines A (bit 0) to G (bit 6), active high |
| dig_en_o | output | 2 | Digit enables, one-hot: bit 0 ones, bit 1 tens |

## Verification
The assertions check several rules on every cycle:
- The digit enables stay one-hot.
- The segments are blank whenever the enables swap.
- Slot boundaries are never back to back.
- The value stays within 0..99 and changes only at a boundary, by exactly one.
- The floor holds at 00 and the ceiling at 99.
- The decimal split always adds back up to the binary value.

Other behaviour only the bench's scenarios can show, by comparing against a cycle-level reference model:
- Edge-only stepping.
- Down winning over Up.
- Short mid-slot presses being ignored.
- The exact segment patterns.
- The digit-to-enable pairing.

// File: rtl/updown_disp_pkg.sv
package updown_disp_pkg;

    localparam int CNT_W      = 7;
    localparam int BCD_W      = 4;
    localparam int SEG_W      = 7;
    localparam int COUNT_MAX  = 99;
    localparam int TENS_STEPS = 4;
    localparam int DIGITS     = 2;

    typedef logic [CNT_W-1:0]  count_t;
    typedef logic [BCD_W-1:0]  digit_t;
    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [DIGITS-1:0] en_t;

    typedef struct packed {
        digit_t tens;
        digit_t ones;
    } bcd_pair_t;

    typedef struct packed {
        logic up;
        logic dn;
    } btn_t;

    // Display slot sequencing after a boundary: blank, swap enables, load pattern.
    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_SWAP = 2'd1,
        PH_LOAD = 2'd2
    } phase_e;

    localparam en_t EN_ONES = 2'b01;
    localparam en_t EN_TENS = 2'b10;

    // Segment pattern for one decimal digit, bit 0 = A ... bit 6 = G.
    function automatic seg_t seg_encode(input digit_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync
    import updown_disp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  btn_t raw_n,
    output btn_t pressed
);
    localparam int BW = $bits(btn_t);

    logic [STAGES-1:0][BW-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;  // released
        end else begin
            chain[0] <= raw_n;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign pressed = btn_t'(~chain[STAGES-1]);

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_CYCLES = 400000
) (
    input  logic clk,
    input  logic rst,
    output logic slot_tick
);
    localparam int TW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(SLOT_CYCLES - 1);

    logic [TW-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst || cyc == LAST) cyc <= '0;
        else                    cyc <= cyc + 1'b1;
    end

    assign slot_tick = (cyc == LAST);

    // R2: boundaries are spaced by a full slot, never adjacent
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        slot_tick |=> !slot_tick);

endmodule

// File: rtl/sat_counter.sv
module sat_counter
    import updown_disp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   slot_tick,
    input  btn_t   pressed,
    output count_t value
);
    localparam count_t TOP = count_t'(COUNT_MAX);

    btn_t prev;
    btn_t fresh;

    always_comb begin
        fresh.up = pressed.up & ~prev.up;
        fresh.dn = pressed.dn & ~prev.dn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            prev  <= '0;
        end else if (slot_tick) begin
            prev <= pressed;
            if (fresh.dn) begin
                if (value != '0) value <= value - 1'b1;
            end else if (fresh.up) begin
                if (value != TOP) value <= value + 1'b1;
            end
        end
    end

    // R7: value stays in range
    p_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        value <= TOP);

    // R4: value moves only at a slot boundary
    p_change_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !slot_tick |=> $stable(value));

    // R5: any change is a single step
    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        slot_tick |=> (value == $past(value) + 1'b1) || (value + 1'b1 == $past(value))
                      || (value == $past(value)));

    // R8: floor holds
    p_floor_r8: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && fresh.dn && value == '0) |=> value == '0);

    // R7: ceiling holds
    p_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && !fresh.dn && fresh.up && value == TOP) |=> value == TOP);

    // R6: down wins when both are fresh
    p_down_priority_r6: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && fresh.dn && fresh.up && value != '0) |=> value + 1'b1 == $past(value));

endmodule

// File: rtl/digit_split.sv
module digit_split
    import updown_disp_pkg::*;
(
    input  count_t    value,
    output bcd_pair_t digits
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0]         rem  [TENS_STEPS+1];
    logic [TENS_STEPS-1:0] tbit;

    assign rem[0] = RW'(value);

    for (genvar i = 0; i < TENS_STEPS; i++) begin : g_step
        localparam logic [RW-1:0] WEIGHT = RW'(10 << (TENS_STEPS - 1 - i));
        logic [RW-1:0] diff;
        logic          borrow;
        assign diff   = rem[i] - WEIGHT;
        assign borrow = diff[RW-1];
        assign tbit[TENS_STEPS-1-i] = ~borrow;
        assign rem[i+1] = borrow ? rem[i] : diff;
    end

    assign digits.tens = digit_t'(tbit);
    assign digits.ones = digit_t'(rem[TENS_STEPS]);

    // R10: tens and ones reassemble into the binary value
    always_comb begin
        if (!$isunknown(value) && value <= count_t'(COUNT_MAX)) begin
            p_split_r10: assert (32'(digits.tens) * 10 + 32'(digits.ones) == 32'(value)
                                 && digits.ones < 4'd10);
        end
    end

endmodule

// File: rtl/disp_mux.sv
module disp_mux
    import updown_disp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      slot_tick,
    input  bcd_pair_t digits,
    output seg_t      seg,
    output en_t       dig_en
);
    phase_e phase;
    digit_t shown;

    // enables have already swapped when the pattern is loaded
    assign shown = (dig_en == EN_ONES) ? digits.ones : digits.tens;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_HOLD;
            seg    <= '0;
            dig_en <= EN_ONES;
        end else if (slot_tick) begin
            seg   <= '0;
            phase <= PH_SWAP;
        end else begin
            case (phase)
                PH_SWAP: begin
                    dig_en <= (dig_en == EN_ONES) ? EN_TENS : EN_ONES;
                    phase  <= PH_LOAD;
                end
                PH_LOAD: begin
                    seg   <= seg_encode(shown);
                    phase <= PH_HOLD;
                end
                default: phase <= PH_HOLD;
            endcase
        end
    end

    // R2: exactly one digit enabled
    p_onehot_en_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(dig_en) == 1);

    // R3: segments blank while enables swap
    p_blank_swap_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(dig_en) |-> seg == '0);

endmodule

// File: rtl/updown_display_counter.sv
module updown_display_counter
    import updown_disp_pkg::*;
#(
    parameter int SLOT_CYCLES = 400000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_up_n,
    input  logic       btn_dn_n,
    output logic [6:0] seg_o,
    output logic [1:0] dig_en_o
);
    btn_t      raw_n;
    btn_t      pressed;
    logic      slot_tick;
    count_t    value;
    bcd_pair_t digits;
    seg_t      seg;
    en_t       dig_en;

    assign raw_n.up = btn_up_n;
    assign raw_n.dn = btn_dn_n;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_n(raw_n), .pressed(pressed)
    );

    slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .slot_tick(slot_tick)
    );

    sat_counter u_count (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .pressed(pressed), .value(value)
    );

    digit_split u_split (
        .value(value), .digits(digits)
    );

    disp_mux u_mux (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .digits(digits),
        .seg(seg), .dig_en(dig_en)
    );

    assign seg_o    = seg;
    assign dig_en_o = dig_en;

endmodule

// File: tb/sim_updown_display_counter.sv
module sim_updown_display_counter;

    localparam int SLOT = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_n = 1'b1;
    logic       dn_n = 1'b1;
    logic [6:0] seg_o;
    logic [1:0] dig_en_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;  // 50 MHz

    updown_display_counter #(.SLOT_CYCLES(SLOT)) u0 (
        .clk(clk), .rst(rst), .btn_up_n(up_n), .btn_dn_n(dn_n),
        .seg_o(seg_o), .dig_en_o(dig_en_o)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic int unpat(input logic [6:0] s);
        for (int d = 0; d < 10; d++) if (pat(d) == s) return d;
        return -1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_cyc = 0, m_val = 0, m_ph = 0, m_en = 1;
    int   m_seg = 0;
    bit   m_prev_up = 0, m_prev_dn = 0;
    bit   q_up[$] = '{1'b1, 1'b1};
    bit   q_dn[$] = '{1'b1, 1'b1};
    bit   model_on = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_val = 0; m_ph = 0; m_en = 1; m_seg = 0;
            m_prev_up = 0; m_prev_dn = 0;
            q_up = '{1'b1, 1'b1}; q_dn = '{1'b1, 1'b1};
        end else begin
            bit tick, pu, pd;
            tick = (m_cyc == SLOT - 1);
            pu = !q_up[0];
            pd = !q_dn[0];
            if (tick) begin
                if (pd && !m_prev_dn)      m_val = (m_val > 0) ? m_val - 1 : 0;
                else if (pu && !m_prev_up) m_val = (m_val < 99) ? m_val + 1 : 99;
                m_prev_up = pu; m_prev_dn = pd;
                m_seg = 0; m_ph = 1;
            end else if (m_ph == 1) begin
                m_en = (m_en == 1) ? 2 : 1; m_ph = 2;
            end else if (m_ph == 2) begin
                m_seg = pat(m_en == 1 ? m_val % 10 : m_val / 10); m_ph = 0;
            end
            m_cyc = tick ? 0 : m_cyc + 1;
            void'(q_up.pop_front()); q_up.push_back(up_n);
            void'(q_dn.pop_front()); q_dn.push_back(dn_n);
        end
        model_on = 1'b1;
    end

    always @(negedge clk) begin
        if (model_on) begin
            check("R9 seg vs model", int'(seg_o), m_seg);
            check("R2 enables vs model", int'(dig_en_o), m_en);
        end
    end

    // ---------------- scenario helpers ----------------
    task automatic wait_en(input logic [1:0] want);
        logic [1:0] last;
        last = dig_en_o;
        forever begin
            @(negedge clk);
            if (dig_en_o == want && last != want) break;
            last = dig_en_o;
        end
    endtask

    task automatic read_value(output int v, output logic [6:0] t_raw, output logic [6:0] o_raw);
        wait_en(2'b01); repeat (5) @(negedge clk); o_raw = seg_o;
        wait_en(2'b10); repeat (5) @(negedge clk); t_raw = seg_o;
        v = unpat(t_raw) * 10 + unpat(o_raw);
    endtask

    task automatic press(input bit u, input bit d);
        @(negedge clk);
        if (u) up_n = 1'b0;
        if (d) dn_n = 1'b0;
        repeat (2 * SLOT) @(negedge clk);
        up_n = 1'b1; dn_n = 1'b1;
        repeat (2 * SLOT) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        logic [6:0] tr, orw;
        int t0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 seg blank in reset", int'(seg_o), 0);
        check("R1 ones enabled in reset", int'(dig_en_o), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 seg blank after reset", int'(seg_o), 0);
        check("R1 ones enabled after reset", int'(dig_en_o), 1);
        read_value(v, tr, orw);
        check("R1 value 00", v, 0);
        check("R9 zero pattern", int'(orw), 'h3F);

        // R2 slot length and R3 blank on swap
        wait_en(2'b10);
        check("R3 blank at swap", int'(seg_o), 0);
        t0 = 0;
        while (dig_en_o != 2'b01) begin @(negedge clk); t0++; end
        check("R2 slot length", t0, SLOT);

        // R4 up presses
        repeat (3) press(1, 0);
        read_value(v, tr, orw);
        check("R4 three ups", v, 3);
        // R4 held button steps once
        @(negedge clk); up_n = 1'b0;
        repeat (6 * SLOT) @(negedge clk);
        up_n = 1'b1;
        repeat (2 * SLOT) @(negedge clk);
        read_value(v, tr, orw);
        check("R4 held steps once", v, 4);

        // R5 down press
        press(0, 1);
        read_value(v, tr, orw);
        check("R5 one down", v, 3);

        // R6 both at once
        press(1, 1);
        read_value(v, tr, orw);
        check("R6 down priority", v, 2);

        // R11 short mid-slot pulse ignored
        wait_en(2'b01);
        repeat (5) @(negedge clk);
        up_n = 1'b0;
        repeat (3) @(negedge clk);
        up_n = 1'b1;
        repeat (3 * SLOT) @(negedge clk);
        read_value(v, tr, orw);
        check("R11 short pulse ignored", v, 2);

        // R8 floor
        repeat (4) press(0, 1);
        read_value(v, tr, orw);
        check("R8 floor at 00", v, 0);

        // R7 ceiling, R10 digits
        repeat (57) press(1, 0);
        read_value(v, tr, orw);
        check("R10 value 57", v, 57);
        check("R9 five pattern", int'(tr), 'h6D);
        check("R9 seven pattern", int'(orw), 'h07);
        repeat (46) press(1, 0);
        read_value(v, tr, orw);
        check("R7 ceiling at 99", v, 99);
        check("R9 nine pattern", int'(orw), 'h6F);
        press(0, 1);
        read_value(v, tr, orw);
        check("R10 value 98", v, 98);
        check("R9 eight pattern", int'(orw), 'h7F);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule